// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two IEEE-754 operands and records the outcome as a 2-bit condition code inside a 32-bit floating-point status word. The operands can be single or double precision. A caller presents both operands, a precision select, a selector that picks one of four condition fields, the current status word and a valid strobe. One clock later the block returns the updated status word.

An unordered compare means that at least one operand is a NaN. What happens then depends on the invalid-trap enable bit of the incoming status word. If the bit is clear, the block sets the invalid accrued flag. If the bit is set, the block asks for a trap for one cycle. In both cases the selected field receives the unordered code. Rounding, arithmetic and trap handling belong to other blocks.

Top module: `fcc_unit`

## Requirements
- R1: In the cycle after a clock edge with `rst_n` low, `stat_out` is 0, `out_valid` is 0 and `trap_req` is 0.
- R2: The condition code written is 0 when the operands are equal, 1 when `op_a` is less than `op_b`, 2 when `op_a` is greater than `op_b`, and 3 when they are unordered.
- R3: `cc_sel` picks where the code goes: 0 writes bits 11:10, 1 writes bits 23:22, 2 writes bits 25:24, and 3 writes bits 27:26. The old contents of that field are replaced. Every other bit, apart from bit 9 under R4, is copied from `stat_in`.
- R4: On an unordered compare with `stat_in[28]` (invalid-trap enable) clear, bit 9 (invalid accrued) of `stat_out` is set and `trap_req` stays low.
- R5: On an unordered compare with `stat_in[28]` set, `trap_req` is high for that result cycle and bit 9 is copied unchanged from `stat_in`.
- R6: An operand is a NaN when its exponent is all ones and its fraction is nonzero, whether quiet or signalling. An all-ones exponent with a zero fraction is an infinity, and an infinity is ordered.
- R7: Positive and negative zero compare equal. Infinities are ordered by sign. Among negative numbers, the one with the larger magnitude is the smaller value. Denormals are ordered by value.
- R8: With `dbl_sel` = 0 only `op_a[31:0]` and `op_b[31:0]` are used, and bits 63:32 have no effect. With `dbl_sel` = 1 all 64 bits form a double.
- R9: A result and `out_valid` appear on the clock edge after the edge that samples `in_valid` high. While `in_valid` is low, `stat_out` holds its value and `trap_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Compare request strobe |
| dbl_sel | input | 1 | 1 = double precision, 0 = single precision (low 32 bits) |
| cc_sel | input | 2 | Target condition field |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| stat_in | input | 32 | Current status word |
| stat_out | output | 32 | Updated status word, registered |
| out_valid | output | 1 | `stat_out` holds a new result |
| trap_req | output | 1 | One-cycle invalid-operation trap request |

## Verification
The hardest cases to reach are the sign-and-magnitude corners. Examples are negative zero against positive zero, two negative numbers whose raw bit patterns order the opposite way to their values, and signalling NaNs whose fraction is a single low bit. The bench reaches them with a table of special values for each precision. Each value carries a numeric rank and a NaN flag. The bench runs every pair through all four fields with the trap enable both clear and set, and for single precision it fills the upper operand bits with junk.

// File: rtl/fcc_pkg.sv
// Package: shared types for the floating-point compare condition unit.
// Assumes a 2-bit condition code and a 32-bit status word.
package fcc_pkg;
    typedef enum logic [1:0] {
        CC_EQ = 2'd0,
        CC_LT = 2'd1,
        CC_GT = 2'd2,
        CC_UN = 2'd3
    } cc_code_t;

    localparam int NUM_FIELDS = 4;
    localparam int CC_W       = 2;
endpackage

// File: rtl/fcc_magcmp.sv
// fcc_magcmp: orders two IEEE-754 values of one format and returns a
// condition code. Assumes sign-magnitude layout {sign, exponent, fraction}.
module fcc_magcmp
    import fcc_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] a,
    input  logic [EXP_W+MAN_W:0] b,
    output cc_code_t             code
);
    localparam int W = EXP_W + MAN_W + 1;

    logic           a_sign, b_sign, a_nan, b_nan, both_zero;
    logic [W-2:0]   a_mag, b_mag;

    // Split operands and classify NaNs and zeros.
    always_comb begin
        a_sign    = a[W-1];
        b_sign    = b[W-1];
        a_mag     = a[W-2:0];
        b_mag     = b[W-2:0];
        a_nan     = (&a[W-2 -: EXP_W]) && (|a[MAN_W-1:0]);
        b_nan     = (&b[W-2 -: EXP_W]) && (|b[MAN_W-1:0]);
        both_zero = (a_mag == '0) && (b_mag == '0);
    end

    // Pick the code: unordered, signed zeros, sign split, then magnitude.
    always_comb begin
        if (a_nan || b_nan)
            code = CC_UN;
        else if (both_zero || (a == b))
            code = CC_EQ;
        else if (a_sign != b_sign)
            code = a_sign ? CC_LT : CC_GT;
        else if (a_sign ? (a_mag > b_mag) : (a_mag < b_mag))
            code = CC_LT;
        else
            code = CC_GT;
    end
endmodule

// File: rtl/fcc_field_upd.sv
// fcc_field_upd: writes a condition code into one of four status fields and
// applies the invalid-operation policy. Assumes field positions do not
// overlap each other, the accrued bit or the trap-enable bit.
module fcc_field_upd
    import fcc_pkg::*;
#(
    parameter int STAT_W   = 32,
    parameter int CC0_POS  = 10,
    parameter int CC1_POS  = 22,
    parameter int CC2_POS  = 24,
    parameter int CC3_POS  = 26,
    parameter int ACCR_BIT = 9,
    parameter int TEN_BIT  = 28
) (
    input  logic [STAT_W-1:0] stat_in,
    input  logic [1:0]        sel,
    input  cc_code_t          code,
    output logic [STAT_W-1:0] stat_nxt,
    output logic              trap
);
    localparam int POS [NUM_FIELDS] = '{CC0_POS, CC1_POS, CC2_POS, CC3_POS};

    logic [NUM_FIELDS-1:0] hit;

    // One decoded enable per field.
    for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_dec
        assign hit[k] = (sel == k[1:0]);
    end

    // Build the new status word from the selected field and NaN policy.
    always_comb begin
        stat_nxt = stat_in;
        for (int k = 0; k < NUM_FIELDS; k++) begin
            if (hit[k])
                stat_nxt[POS[k] +: CC_W] = code;
        end
        trap = 1'b0;
        if (code == CC_UN) begin
            if (stat_in[TEN_BIT])
                trap = 1'b1;
            else
                stat_nxt[ACCR_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/fcc_unit.sv
// fcc_unit: top of the compare condition unit. Compares single or double
// operands, updates the status word and raises a one-cycle trap request.
// Assumes stat_in is stable for the cycle in which in_valid is high.
module fcc_unit
    import fcc_pkg::*;
#(
    parameter int STAT_W   = 32,
    parameter int CC0_POS  = 10,
    parameter int CC1_POS  = 22,
    parameter int CC2_POS  = 24,
    parameter int CC3_POS  = 26,
    parameter int ACCR_BIT = 9,
    parameter int TEN_BIT  = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              dbl_sel,
    input  logic [1:0]        cc_sel,
    input  logic [63:0]       op_a,
    input  logic [63:0]       op_b,
    input  logic [STAT_W-1:0] stat_in,
    output logic [STAT_W-1:0] stat_out,
    output logic              out_valid,
    output logic              trap_req
);
    localparam int NPREC = 2;
    localparam logic [STAT_W-1:0] KEEP_MASK = ~(
        ({{(STAT_W-2){1'b0}}, 2'b11} << CC0_POS) |
        ({{(STAT_W-2){1'b0}}, 2'b11} << CC1_POS) |
        ({{(STAT_W-2){1'b0}}, 2'b11} << CC2_POS) |
        ({{(STAT_W-2){1'b0}}, 2'b11} << CC3_POS) |
        ({{(STAT_W-1){1'b0}}, 1'b1}  << ACCR_BIT));

    cc_code_t          prec_code [NPREC];
    cc_code_t          code;
    logic [STAT_W-1:0] stat_nxt;
    logic              trap_nxt;

    // One comparator per precision; index 0 single, index 1 double.
    for (genvar p = 0; p < NPREC; p++) begin : g_prec
        localparam int EW = (p == 0) ? 8 : 11;
        localparam int MW = (p == 0) ? 23 : 52;
        localparam int W  = EW + MW + 1;
        fcc_magcmp #(.EXP_W(EW), .MAN_W(MW)) u_cmp (
            .a    (op_a[W-1:0]),
            .b    (op_b[W-1:0]),
            .code (prec_code[p])
        );
    end

    // Select the code of the requested precision.
    assign code = dbl_sel ? prec_code[1] : prec_code[0];

    fcc_field_upd #(
        .STAT_W(STAT_W), .CC0_POS(CC0_POS), .CC1_POS(CC1_POS),
        .CC2_POS(CC2_POS), .CC3_POS(CC3_POS),
        .ACCR_BIT(ACCR_BIT), .TEN_BIT(TEN_BIT)
    ) u_upd (
        .stat_in  (stat_in),
        .sel      (cc_sel),
        .code     (code),
        .stat_nxt (stat_nxt),
        .trap     (trap_nxt)
    );

    // Result register: load on a request, hold otherwise, pulse trap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_out  <= '0;
            out_valid <= 1'b0;
            trap_req  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            trap_req  <= in_valid && trap_nxt;
            if (in_valid)
                stat_out <= stat_nxt;
        end
    end

    // R5: a trap only follows a request whose trap enable was set.
    p_trap_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(stat_in[TEN_BIT]));

    // R5: a trapping compare leaves the accrued flag as it came in.
    p_trap_keeps_accrued_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (stat_out[ACCR_BIT] == $past(stat_in[ACCR_BIT])));

    // R9: a trap request always comes with a valid result.
    p_trap_with_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> out_valid);

    // R9: with no request the status word holds and no trap is raised.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(stat_out) && !trap_req));

    // R3: bits outside the fields and the accrued flag pass through.
    p_other_bits_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((stat_out & KEEP_MASK) == ($past(stat_in) & KEEP_MASK)));
endmodule

// File: tb/tb_fcc_unit.sv
module tb_fcc_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        dbl_sel;
    logic [1:0]  cc_sel;
    logic [63:0] op_a, op_b;
    logic [31:0] stat_in;
    logic [31:0] stat_out;
    logic        out_valid, trap_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    fcc_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dbl_sel(dbl_sel),
        .cc_sel(cc_sel), .op_a(op_a), .op_b(op_b), .stat_in(stat_in),
        .stat_out(stat_out), .out_valid(out_valid), .trap_req(trap_req)
    );

    localparam int NV = 13;

    // Test value table: index -> encoding for single (dbl=0) or double.
    function automatic logic [63:0] tval(input int i, input bit dbl);
        case (i)
            0:  return dbl ? 64'h0000000000000000 : 64'h00000000;
            1:  return dbl ? 64'h8000000000000000 : 64'h80000000;
            2:  return dbl ? 64'h3FF0000000000000 : 64'h3F800000;
            3:  return dbl ? 64'hBFF0000000000000 : 64'hBF800000;
            4:  return dbl ? 64'h4000000000000000 : 64'h40000000;
            5:  return dbl ? 64'hC000000000000000 : 64'hC0000000;
            6:  return dbl ? 64'h7FF0000000000000 : 64'h7F800000;
            7:  return dbl ? 64'hFFF0000000000000 : 64'hFF800000;
            8:  return dbl ? 64'h7FF8000000000000 : 64'h7FC00000;
            9:  return dbl ? 64'h7FF0000000000001 : 64'h7F800001;
            10: return dbl ? 64'h0000000000000001 : 64'h00000001;
            11: return dbl ? 64'hFFEFFFFFFFFFFFFF : 64'hFF7FFFFF;
            default: return dbl ? 64'h7FEFFFFFFFFFFFFF : 64'h7F7FFFFF;
        endcase
    endfunction

    // Numeric rank of each table value (NaNs unranked).
    function automatic int rank(input int i);
        case (i)
            0, 1: return 4;
            2: return 6;   3: return 3;   4: return 7;  5: return 2;
            6: return 9;   7: return 0;   10: return 5; 11: return 1;
            12: return 8;
            default: return -1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_one(input int ia, input int ib, input bit dbl,
                           input int sel, input bit ten, input int seq);
        logic [1:0]  code;
        logic [31:0] s, e;
        logic [31:0] junk;
        int          pos;
        bit          etrap;
        logic [31:0] held;
        if (ia == 8 || ia == 9 || ib == 8 || ib == 9) code = 2'd3;
        else if (rank(ia) == rank(ib))                code = 2'd0;
        else if (rank(ia) < rank(ib))                 code = 2'd1;
        else                                          code = 2'd2;
        s       = 32'h9E3779B9 * (seq + 1);
        s[28]   = ten;
        junk    = 32'hDEAD0000 ^ seq;
        pos     = (sel == 0) ? 10 : 20 + 2 * sel;
        e       = s & ~(32'h3 << pos);
        e       = e | ({30'd0, code} << pos);
        etrap   = (code == 2'd3) && ten;
        if (code == 2'd3 && !ten) e[9] = 1'b1;
        @(negedge clk);
        in_valid = 1'b1; dbl_sel = dbl; cc_sel = sel[1:0]; stat_in = s;
        op_a = dbl ? tval(ia, 1'b1) : {junk, tval(ia, 1'b0)[31:0]};
        op_b = dbl ? tval(ib, 1'b1) : {~junk, tval(ib, 1'b0)[31:0]};
        @(negedge clk);
        // R2/R3/R6/R7/R8: code, field placement, NaN and ordering rules.
        check(stat_out == e, dbl ? "R2/R3/R6/R7 double" : "R2/R3/R6/R7/R8 single",
              {32'd0, stat_out}, {32'd0, e});
        if (code == 2'd3)
            check(trap_req == etrap, ten ? "R5 trap" : "R4 no trap",
                  {63'd0, trap_req}, {63'd0, etrap});
        else
            check(trap_req == 1'b0, "R2 ordered no trap", {63'd0, trap_req}, 64'd0);
        check(out_valid == 1'b1, "R9 valid", {63'd0, out_valid}, 64'd1);
        // R9: idle cycle with changed inputs must not alter the result.
        held = stat_out;
        in_valid = 1'b0; stat_in = ~s; op_a = ~op_a;
        @(negedge clk);
        check(stat_out == held && !trap_req && !out_valid, "R9 hold",
              {31'd0, trap_req, stat_out}, {32'd0, held});
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; dbl_sel = 1'b0; cc_sel = 2'd0;
        op_a = '0; op_b = '0; stat_in = 32'hFFFFFFFF;
        repeat (2) @(negedge clk);
        // R1: reset state.
        check(stat_out == 32'd0 && !out_valid && !trap_req, "R1 reset",
              {30'd0, out_valid, trap_req, stat_out}, 64'd0);
        rst_n = 1'b1;
        begin
            int seq = 0;
            for (int d = 0; d < 2; d++)
                for (int t = 0; t < 2; t++)
                    for (int sl = 0; sl < 4; sl++)
                        for (int ia = 0; ia < NV; ia++)
                            for (int ib = 0; ib < NV; ib++) begin
                                run_one(ia, ib, d[0], sl, t[0], seq);
                                seq++;
                            end
        end
        // R1: reset again mid-run clears a loaded result.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(stat_out == 32'd0 && !out_valid && !trap_req, "R1 re-reset",
              {30'd0, out_valid, trap_req, stat_out}, 64'd0);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule